// File: doc/BRIEF.md
# Packed Key-Compare Mask and Pixel Merge

This block takes a 64-bit word holding eight 8-bit foreground pixels and a second 64-bit background word. It compares every foreground byte with one key byte. The key byte is copied into all eight lanes before the compare. Two compare types are supported:

- byte equality;
- signed greater-than.

Each lane's compare result is widened into a lane mask of all ones or all zeros. That mask then merges the two words without any per-pixel branching. In a set lane the background byte replaces the foreground byte. In a clear lane the foreground byte is kept. The typical use is chroma keying: foreground pixels that carry the key colour are swapped for the other picture.

The caller presents both words, the key and the compare type together with a one-cycle valid strobe. The mask and the merged word are registered together and appear on the clock edge that samples the strobe. An output valid flag marks that cycle. Between strobes the registered results keep their values. The compare produces only the mask and no separate flag or status output.

Top module: `keyed_lane_merge`

## Requirements
- R1: While `rst_n` is low, `out_vld`, `out_mask` and `out_word` are all zero.
- R2: With `cmp_mode` = 0 (equality), lane k of `out_mask` (bits 8k+7..8k) is 8'hFF when foreground byte k equals `key_byte`, else 8'h00.
- R3: With `cmp_mode` = 1 (signed greater-than), lane k of `out_mask` is 8'hFF when foreground byte k, read as two's complement, is strictly greater than `key_byte` read the same way, else 8'h00.
- R4: Lane k of `out_word` equals background byte k where the lane mask is set, and foreground byte k where it is clear.
- R5: The key is applied to all eight lanes, and each lane's result depends only on its own foreground byte; a key match in lane k alone sets only mask lane k.
- R6: Mask, merged word and `out_vld` = 1 appear on the first rising edge at which `in_vld` is sampled high; `out_vld` is high for exactly the cycles following a sampled strobe.
- R7: When `in_vld` is low, `out_mask` and `out_word` keep their previous values whatever the data inputs do, and `out_vld` is 0 on the next cycle.
- R8: When every lane matches, `out_word` equals the background word exactly; when no lane matches, it equals the foreground word exactly.
- R9: Every 8-bit lane of `out_mask` is either all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Strobe: sample the inputs this cycle |
| cmp_mode | input | 1 | Compare type: 0 = equality, 1 = signed greater-than |
| fg_word | input | 64 | Eight foreground pixels, lane k in bits 8k+7..8k |
| bg_word | input | 64 | Eight background pixels, same lane order |
| key_byte | input | 8 | Key or threshold byte, copied to every lane |
| out_vld | output | 1 | High one cycle after a sampled strobe |
| out_mask | output | 64 | Registered per-lane mask |
| out_word | output | 64 | Registered merged pixel word |

## Verification
Every result from this block is due one register stage after its strobe. The bench drives inputs on the falling edge, so the next rising edge captures them. It then reads `out_vld`, `out_mask` and `out_word` at the falling edge that follows, half a period after that capture.

The hold behaviour is checked in a different way. The bench scrambles the data inputs with the strobe low, lets two rising edges pass, and confirms the outputs still show the values captured earlier.

The main sweep covers every key value in both compare types. Each foreground byte value is placed in a rotating lane position, and the expected mask and merge are computed per lane with bench arithmetic.

// File: rtl/klm_pkg.sv
package klm_pkg;
    localparam int unsigned KLM_LANES  = 8;
    localparam int unsigned KLM_LANE_W = 8;

    typedef enum logic {
        CMP_EQ = 1'b0,
        CMP_GT = 1'b1
    } cmp_kind_e;
endpackage

// File: rtl/klm_lane_cmp.sv
module klm_lane_cmp
    import klm_pkg::*;
#(
    parameter int unsigned LANE_W = KLM_LANE_W
) (
    input  logic [LANE_W-1:0] lane_px,
    input  logic [LANE_W-1:0] lane_key,
    input  cmp_kind_e         kind,
    output logic [LANE_W-1:0] lane_mask
);
    logic hit;

    always_comb begin
        unique case (kind)
            CMP_GT:  hit = $signed(lane_px) > $signed(lane_key);
            default: hit = (lane_px == lane_key);
        endcase
        lane_mask = {LANE_W{hit}};
    end
endmodule

// File: rtl/klm_merge.sv
module klm_merge #(
    parameter int unsigned WORD_W = 64
) (
    input  logic [WORD_W-1:0] keep_word,
    input  logic [WORD_W-1:0] swap_word,
    input  logic [WORD_W-1:0] sel_mask,
    output logic [WORD_W-1:0] merged
);
    logic [WORD_W-1:0] from_swap;
    logic [WORD_W-1:0] from_keep;

    always_comb begin
        from_swap = swap_word & sel_mask;
        from_keep = keep_word & ~sel_mask;
        merged    = from_swap | from_keep;
    end
endmodule

// File: rtl/keyed_lane_merge.sv
module keyed_lane_merge
    import klm_pkg::*;
#(
    parameter int unsigned LANES  = KLM_LANES,
    parameter int unsigned LANE_W = KLM_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic                    cmp_mode,
    input  logic [LANES*LANE_W-1:0] fg_word,
    input  logic [LANES*LANE_W-1:0] bg_word,
    input  logic [LANE_W-1:0]       key_byte,
    output logic                    out_vld,
    output logic [LANES*LANE_W-1:0] out_mask,
    output logic [LANES*LANE_W-1:0] out_word
);
    localparam int unsigned WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] data;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    cmp_kind_e         kind;
    logic [WORD_W-1:0] key_wide;
    logic [WORD_W-1:0] mask_now;
    logic [WORD_W-1:0] merge_now;

    assign kind     = cmp_kind_e'(cmp_mode);
    assign key_wide = {LANES{key_byte}};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        klm_lane_cmp #(.LANE_W(LANE_W)) u_cmp (
            .lane_px   (fg_word[g*LANE_W +: LANE_W]),
            .lane_key  (key_wide[g*LANE_W +: LANE_W]),
            .kind      (kind),
            .lane_mask (mask_now[g*LANE_W +: LANE_W])
        );

        AST_LANE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.mask[g*LANE_W +: LANE_W] == '0) ||
            (st_q.mask[g*LANE_W +: LANE_W] == '1)); // R9
    end

    klm_merge #(.WORD_W(WORD_W)) u_merge (
        .keep_word (fg_word),
        .swap_word (bg_word),
        .sel_mask  (mask_now),
        .merged    (merge_now)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.mask = mask_now;
            st_d.data = merge_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld;
    assign out_mask = st_q.mask;
    assign out_word = st_q.data;

    AST_VLD_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld); // R6
    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_mask) && $stable(out_word))); // R7
    AST_BG_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (((out_word ^ $past(bg_word)) & out_mask) == '0)); // R4
    AST_FG_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (((out_word ^ $past(fg_word)) & ~out_mask) == '0)); // R4
    AST_ALL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (mask_now == '1)) |=> (out_word == $past(bg_word))); // R8
    AST_NONE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (mask_now == '0)) |=> (out_word == $past(fg_word))); // R8
endmodule

// File: tb/keyed_lane_merge_tb.sv
`timescale 1ns/1ps
module keyed_lane_merge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic        cmp_mode = 1'b0;
    logic [63:0] fg_word = '0;
    logic [63:0] bg_word = '0;
    logic [7:0]  key_byte = '0;
    logic        out_vld;
    logic [63:0] out_mask;
    logic [63:0] out_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    keyed_lane_merge u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cmp_mode(cmp_mode),
        .fg_word(fg_word), .bg_word(bg_word), .key_byte(key_byte),
        .out_vld(out_vld), .out_mask(out_mask), .out_word(out_word)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_mask(logic [63:0] fg, logic [7:0] key, logic mode);
        logic [63:0] m = '0;
        for (int k = 0; k < 8; k++) begin
            int a = int'(fg[8*k +: 8]);
            int b = int'(key);
            if (mode) begin
                if (a > 127) a = a - 256;
                if (b > 127) b = b - 256;
                if (a > b) m[8*k +: 8] = 8'hFF;
            end else if (a == b) begin
                m[8*k +: 8] = 8'hFF;
            end
        end
        return m;
    endfunction

    function automatic logic [63:0] model_word(logic [63:0] fg, logic [63:0] bg, logic [63:0] m);
        logic [63:0] w;
        for (int k = 0; k < 8; k++)
            w[8*k +: 8] = (m[8*k] == 1'b1) ? bg[8*k +: 8] : fg[8*k +: 8];
        return w;
    endfunction

    // drive at falling edge, captured next rising edge, read at following falling edge
    task automatic apply(logic [63:0] fg, logic [63:0] bg, logic [7:0] key, logic mode,
                         string req);
        logic [63:0] em;
        fg_word = fg; bg_word = bg; key_byte = key; cmp_mode = mode; in_vld = 1'b1;
        em = model_mask(fg, key, mode);
        @(negedge clk);
        in_vld = 1'b0;
        chk({req, " R6 out_vld"}, {63'd0, out_vld}, 64'd1);
        chk({req, " mask R9"}, out_mask, em);
        chk({req, " word R4"}, out_word, model_word(fg, bg, em));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] hm, hw, fg;
        repeat (3) @(negedge clk);
        chk("R1 reset vld", {63'd0, out_vld}, 64'd0);
        chk("R1 reset mask", out_mask, 64'd0);
        chk("R1 reset word", out_word, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 sweep: every key, every foreground value in rotating lanes
        for (int md = 0; md < 2; md++)
            for (int key = 0; key < 256; key++)
                for (int base = 0; base < 256; base += 8) begin
                    for (int k = 0; k < 8; k++)
                        fg[8*k +: 8] = 8'(base + ((k + key) % 8));
                    apply(fg, ~fg ^ 64'h0123_4567_89AB_CDEF, 8'(key), md[0],
                          md[0] ? "R3 sweep" : "R2 sweep");
                end

        // R5: key present in one lane only
        for (int k = 0; k < 8; k++) begin
            fg = {8{8'h11}};
            fg[8*k +: 8] = 8'h3C;
            apply(fg, {8{8'hEE}}, 8'h3C, 1'b0, "R5 single lane");
            chk("R5 only lane set", out_mask, 64'hFF << (8*k));
        end

        // R8: all and none
        apply({8{8'h40}}, 64'hDEAD_BEEF_0BAD_F00D, 8'h40, 1'b0, "R8 all");
        chk("R8 all equals bg", out_word, 64'hDEAD_BEEF_0BAD_F00D);
        apply(64'h0102_0304_0506_0708, 64'hFFFF_0000_FFFF_0000, 8'h7F, 1'b1, "R8 none");
        chk("R8 none equals fg", out_word, 64'h0102_0304_0506_0708);
        apply({8{8'h80}}, 64'h5555_AAAA_5555_AAAA, 8'h80, 1'b1, "R3 equal not greater");
        chk("R3 equal gives zero mask", out_mask, 64'd0);

        // R7: hold while idle
        apply(64'h00FF_1234_00FF_5678, 64'hCAFE_CAFE_CAFE_CAFE, 8'h00, 1'b0, "R7 setup");
        hm = out_mask; hw = out_word;
        fg_word = 64'h0; bg_word = '1; key_byte = 8'h00; cmp_mode = 1'b1;
        @(negedge clk);
        chk("R7 vld low", {63'd0, out_vld}, 64'd0);
        @(negedge clk);
        chk("R7 mask held", out_mask, hm);
        chk("R7 word held", out_word, hw);

        // R6: back-to-back strobes
        apply({8{8'h05}}, {8{8'h99}}, 8'h05, 1'b0, "R6 b2b first");
        apply({8{8'h05}}, {8{8'h99}}, 8'h06, 1'b0, "R6 b2b second");
        chk("R6 second result", out_word, {8{8'h05}});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule